// File: doc/BRIEF.md
# Dynamic Scan Channel Router

This block connects a small set of tester scan channels to the compressed-scan pins of several wrapped cores. On the stimulus side, each tester input channel passes through its own demultiplexer. The demultiplexer sends the channel's scan bit to one decompressor input pin on every core whose configured core address matches the channel's 4-bit routing code. When several channels can reach the same core pin, their demultiplexer outputs are combined with an OR gate. Outputs that are not selected drive 0, so two channels aimed at the same pin merge. Cores that are identical are given the same core address, and one channel then broadcasts the same data to all of them.

On the response side, each tester output channel has a multiplexer. The multiplexer picks the compactor output of one core, chosen by that output channel's own 4-bit code. The routing codes live in shadow registers. A dedicated control chain loads them serially before each pattern group. Because a separate update strobe copies the chain into the shadows, the routing stays fixed while the next configuration shifts in.

Top module: `scan_route_top`

## Requirements
- R1: While `cfgShiftEn` is high, each clock shifts `cfgSi` into the control chain, least significant bit first. The chain is `(NUM_IN_CH+NUM_OUT_CH)*4` bits long. After a full load, stream bits `4*i..4*i+3` hold the code of input channel `i`, and stream bits `4*(NUM_IN_CH+o)..+3` hold the code of output channel `o`.
- R2: Routing changes only at a clock edge where `cfgUpdate` is high. Shifting the chain without an update leaves every core input and tester output unchanged.
- R3: After reset, and until the first update, all shadow codes are 4'hF. In that state every `coreIn` bit and every `tstOut` bit is 0.
- R4: Input channel `i` with code `a` drives `tstIn[i]` onto pin `i mod CORE_IN_W` of every core whose core address equals `a`. Core `c` pin `p` is `coreIn[c*CORE_IN_W+p]`. Every other demultiplexer output is 0.
- R5: A core pin reachable from several channels carries the OR of all channels currently routed to it.
- R6: Cores that share a core address receive the same channel data at once. With the default addresses {core0:0, core1:1, core2:2, core3:2}, code 2 broadcasts to cores 2 and 3.
- R7: Output channel `o` with code `a < NUM_CORES` drives `coreOut[a]` onto `tstOut[o]`.
- R8: An input code that matches no core address (4'hF included) drives no core. An output code of `NUM_CORES` or above drives `tstOut[o]` to 0.
- R9: If `cfgUpdate` and `cfgShiftEn` are high on the same edge, the shadows capture the chain contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control chain and shadow registers |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgShiftEn | input | 1 | Shift enable for the control chain |
| cfgSi | input | 1 | Serial control data in |
| cfgUpdate | input | 1 | Copies the control chain into the shadow codes |
| tstIn | input | NUM_IN_CH | Tester scan input channels |
| coreIn | output | NUM_CORES*CORE_IN_W | Core decompressor input pins |
| coreOut | input | NUM_CORES | Core compactor outputs |
| tstOut | output | NUM_OUT_CH | Tester scan output channels |

## Verification
The hold property assumes two things. First, `cfgUpdate` is low during the cycle after reset is released. Second, no configured core address equals the idle code 4'hF. The stimulus keeps `cfgUpdate` low except for the single-cycle commit pulses, and it uses only the default core addresses. The bench changes tester and compactor inputs on falling edges only. It loads configurations that cover direct routing, OR-merging, broadcast, idle codes and a simultaneous shift-and-update, and it compares every core pin and output channel against its own routing model.

// File: rtl/scan_route_pkg.sv
package scan_route_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] IDLE_CODE = 4'hF;

  typedef struct packed {
    logic shift;
    logic update;
  } routeStrobe_t;
endpackage

// File: rtl/scan_route_ctrl.sv
module scan_route_ctrl
  import scan_route_pkg::*;
(
  input  logic         cfgShiftEn,
  input  logic         cfgUpdate,
  output routeStrobe_t stb
);
  always_comb begin
    stb.shift  = cfgShiftEn;
    stb.update = cfgUpdate;
  end
endmodule

// File: rtl/scan_route_datapath.sv
module scan_route_datapath
  import scan_route_pkg::*;
#(
  parameter int NUM_IN_CH  = 4,
  parameter int NUM_OUT_CH = 2,
  parameter int NUM_CORES  = 4,
  parameter int CORE_IN_W  = 2,
  parameter logic [NUM_CORES*ADDR_W-1:0] CORE_ADDR = 16'h2210
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  routeStrobe_t                  stb,
  input  logic                          cfgSi,
  input  logic [NUM_IN_CH-1:0]          tstIn,
  output logic [NUM_CORES*CORE_IN_W-1:0] coreIn,
  input  logic [NUM_CORES-1:0]          coreOut,
  output logic [NUM_OUT_CH-1:0]         tstOut
);
  localparam int CHAIN_LEN = (NUM_IN_CH + NUM_OUT_CH) * ADDR_W;

  logic [CHAIN_LEN-1:0] chainQ;
  logic [CHAIN_LEN-1:0] shadowQ;

  // Control chain (R1) and shadow copy (R2, R9); reset makes every code idle (R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ  <= '1;
      shadowQ <= '1;
    end else begin
      if (stb.shift)  chainQ  <= {cfgSi, chainQ[CHAIN_LEN-1:1]};
      if (stb.update) shadowQ <= chainQ;
    end
  end

  // Demultiplexers with OR-merge at each core pin (R4, R5, R6, R8)
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar p = 0; p < CORE_IN_W; p++) begin : g_pin
      logic [NUM_IN_CH-1:0] hit;
      always_comb begin
        for (int i = 0; i < NUM_IN_CH; i++) begin
          hit[i] = ((i % CORE_IN_W) == p) &&
                   (shadowQ[i*ADDR_W +: ADDR_W] == CORE_ADDR[c*ADDR_W +: ADDR_W]) &&
                   tstIn[i];
        end
      end
      assign coreIn[c*CORE_IN_W + p] = |hit;
    end
  end

  // Response multiplexers (R7, R8)
  for (genvar o = 0; o < NUM_OUT_CH; o++) begin : g_out
    logic [ADDR_W-1:0] sel;
    logic              outBit;
    assign sel = shadowQ[(NUM_IN_CH + o)*ADDR_W +: ADDR_W];
    always_comb begin
      outBit = 1'b0;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (sel == ADDR_W'(c)) outBit = coreOut[c];
      end
    end
    assign tstOut[o] = outBit;
  end
endmodule

// File: rtl/scan_route_top.sv
module scan_route_top
  import scan_route_pkg::*;
#(
  parameter int NUM_IN_CH  = 4,
  parameter int NUM_OUT_CH = 2,
  parameter int NUM_CORES  = 4,
  parameter int CORE_IN_W  = 2,
  parameter logic [NUM_CORES*ADDR_W-1:0] CORE_ADDR = 16'h2210
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgShiftEn,
  input  logic                           cfgSi,
  input  logic                           cfgUpdate,
  input  logic [NUM_IN_CH-1:0]           tstIn,
  output logic [NUM_CORES*CORE_IN_W-1:0] coreIn,
  input  logic [NUM_CORES-1:0]           coreOut,
  output logic [NUM_OUT_CH-1:0]          tstOut
);
  routeStrobe_t stb;

  scan_route_ctrl u_ctrl (
    .cfgShiftEn (cfgShiftEn),
    .cfgUpdate  (cfgUpdate),
    .stb        (stb)
  );

  scan_route_datapath #(
    .NUM_IN_CH  (NUM_IN_CH),
    .NUM_OUT_CH (NUM_OUT_CH),
    .NUM_CORES  (NUM_CORES),
    .CORE_IN_W  (CORE_IN_W),
    .CORE_ADDR  (CORE_ADDR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cfgSi   (cfgSi),
    .tstIn   (tstIn),
    .coreIn  (coreIn),
    .coreOut (coreOut),
    .tstOut  (tstOut)
  );
endmodule

// File: rtl/scan_route_checker.sv
module scan_route_checker #(
  parameter int NUM_IN_CH  = 4,
  parameter int NUM_OUT_CH = 2,
  parameter int NUM_CORES  = 4,
  parameter int CORE_IN_W  = 2
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           cfgUpdate,
  input logic [NUM_IN_CH-1:0]           tstIn,
  input logic [NUM_CORES*CORE_IN_W-1:0] coreIn,
  input logic [NUM_CORES-1:0]           coreOut,
  input logic [NUM_OUT_CH-1:0]          tstOut
);
  logic seenUpd;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          seenUpd <= 1'b0;
    else if (cfgUpdate) seenUpd <= 1'b1;
  end

  assert_idle_after_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    !seenUpd |-> (coreIn == '0 && tstOut == '0));

  assert_quiet_inputs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tstIn == '0) |-> (coreIn == '0));

  assert_quiet_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (coreOut == '0) |-> (tstOut == '0));

  assert_hold_without_update_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!cfgUpdate) && $stable(tstIn) && $stable(coreOut)) |->
      ($stable(coreIn) && $stable(tstOut)));
endmodule

bind scan_route_top scan_route_checker #(
  .NUM_IN_CH  (NUM_IN_CH),
  .NUM_OUT_CH (NUM_OUT_CH),
  .NUM_CORES  (NUM_CORES),
  .CORE_IN_W  (CORE_IN_W)
) u_chk (.*);

// File: tb/sim_scan_route_top.sv
`timescale 1ns/1ps
module sim_scan_route_top;
  localparam int NI = 4;
  localparam int NO = 2;
  localparam int NC = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgShiftEn = 1'b0;
  logic cfgSi = 1'b0;
  logic cfgUpdate = 1'b0;
  logic [NI-1:0] tstIn = '0;
  logic [NC*PW-1:0] coreIn;
  logic [NC-1:0] coreOut = '0;
  logic [NO-1:0] tstOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Core addresses per R6: core0:0 core1:1 core2:2 core3:2
  int coreId [NC] = '{0, 1, 2, 2};
  int curIn [NI];
  int curOut [NO];
  int pendIn [NI];
  int pendOut [NO];

  always #5 clk = ~clk;

  scan_route_top u0 (
    .clk(clk), .rstN(rstN), .cfgShiftEn(cfgShiftEn), .cfgSi(cfgSi),
    .cfgUpdate(cfgUpdate), .tstIn(tstIn), .coreIn(coreIn),
    .coreOut(coreOut), .tstOut(tstOut)
  );

  function automatic logic [NC*PW-1:0] expCore(logic [NI-1:0] ti);
    logic [NC*PW-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++)
        if (curIn[i] == coreId[c] && ti[i]) r[c*PW + (i % PW)] = 1'b1;
    return r;
  endfunction

  function automatic logic [NO-1:0] expOut(logic [NC-1:0] co);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++)
      if (curOut[o] < NC) r[o] = co[curOut[o]];
    return r;
  endfunction

  task automatic checkNow(string tag);
    logic [NC*PW-1:0] ec;
    logic [NO-1:0] eo;
    ec = expCore(tstIn);
    eo = expOut(coreOut);
    checks++;
    if (coreIn !== ec) begin
      failures++;
      $display("FAIL %s coreIn actual=%b expected=%b", tag, coreIn, ec);
    end
    checks++;
    if (tstOut !== eo) begin
      failures++;
      $display("FAIL %s tstOut actual=%b expected=%b", tag, tstOut, eo);
    end
  endtask

  // Shift a full configuration, LSB first, input codes then output codes (R1)
  task automatic shiftCfg(int a0, int a1, int a2, int a3, int o0, int o1);
    logic [(NI+NO)*4-1:0] stream;
    pendIn = '{a0, a1, a2, a3};
    pendOut = '{o0, o1};
    for (int i = 0; i < NI; i++) stream[i*4 +: 4] = 4'(pendIn[i]);
    for (int o = 0; o < NO; o++) stream[(NI+o)*4 +: 4] = 4'(pendOut[o]);
    for (int k = 0; k < (NI+NO)*4; k++) begin
      @(negedge clk);
      cfgShiftEn = 1'b1;
      cfgSi = stream[k];
    end
    @(negedge clk);
    cfgShiftEn = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfgUpdate = 1'b1;
    @(negedge clk);
    cfgUpdate = 1'b0;
    curIn = pendIn;
    curOut = pendOut;
  endtask

  task automatic randomRun(string tag, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tstIn = NI'($urandom);
      coreOut = NC'($urandom);
      #1;
      checkNow(tag);
    end
  endtask

  task automatic directed(string tag, logic [NI-1:0] ti, logic [NC-1:0] co);
    @(negedge clk);
    tstIn = ti;
    coreOut = co;
    #1;
    checkNow(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    curIn = '{15, 15, 15, 15};
    curOut = '{15, 15};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R3: idle after reset
    directed("R3 reset idle", '1, '1);
    randomRun("R3 reset idle", 10);

    // R4 direct routing, R6 broadcast via code 2, R8 idle input, R7 outputs
    shiftCfg(0, 1, 2, 15, 0, 3);
    commit();
    directed("R4 direct route", 4'b0001, 4'b0001);
    directed("R6 broadcast", 4'b0100, 4'b1000);
    directed("R8 idle channel 3", 4'b1000, 4'b0000);
    randomRun("R4 R6 R7 mixed", 30);

    // R5 OR-merge: ch0 and ch2 both to core1 pin0; R8 unmatched code 5 and output code 15
    shiftCfg(1, 5, 1, 1, 15, 2);
    commit();
    directed("R5 merge one", 4'b0001, 4'b0100);
    directed("R5 merge other", 4'b0100, 4'b0000);
    directed("R5 merge both", 4'b0101, 4'b1111);
    directed("R8 unused code", 4'b0010, 4'b0001);
    randomRun("R5 R8 mixed", 30);

    // R6 broadcast on pin1 from two channels, R8 output code 9
    shiftCfg(15, 2, 0, 2, 1, 9);
    commit();
    directed("R6 broadcast pin1", 4'b0010, 4'b0010);
    randomRun("R6 R8 mixed", 30);

    // R1 full field layout with every channel distinct, then R9
    shiftCfg(3, 0, 2, 1, 2, 1);
    @(negedge clk);
    cfgShiftEn = 1'b1;
    cfgSi = 1'b0;
    cfgUpdate = 1'b1;
    @(negedge clk);
    cfgShiftEn = 1'b0;
    cfgUpdate = 1'b0;
    curIn = pendIn;
    curOut = pendOut;
    randomRun("R9 shift with update", 20);
    randomRun("R1 field layout", 10);

    // R2: shift a new config without update, routing must stay put
    shiftCfg(15, 15, 15, 15, 15, 15);
    randomRun("R2 no update", 20);
    commit();
    randomRun("R8 all idle", 10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule